// File: doc/BRIEF.md
# Modulated Phase-Accumulator Sine Synthesizer Core

This block is the arithmetic core of a direct digital synthesizer. Two 28-bit tuning words are held outside the block. A select pin picks one of them, so the output can flip between two channel frequencies without anything being reloaded. Modulation can be switched on. Its offset comes either from a stored 28-bit shift word or from a 23-bit parallel input, which is sign-extended. The offset is added to the tuning word, and the resulting step is accumulated in a 28-bit phase register.

The accumulator wraps modulo 2^28, so a step with its top bit set acts as a negative value and drives the phase backwards. The phase register advances on every second clock, which means the sample rate is half the clock rate. The output frequency is the sample rate times the step divided by 2^28. The top eight phase bits are mapped onto a 16-bit offset-binary sine sample through a computed 64-entry quarter-wave magnitude table. In that format, 0x8000 is the zero crossing.

Top module: `dds_sine_core`

## Requirements
- R1: While rst_ni is low, sine_o reads 0x8000, valid_o is 0, the phase register is zero and the half-rate divider is cleared.
- R2: A sample tick occurs on every second rising clock edge. valid_o is high for exactly one clock after each tick, so consecutive valid_o pulses are two clocks apart.
- R3: freq_sel_i = 0 selects freq_a_i and freq_sel_i = 1 selects freq_b_i as the base tuning word. The pin is sampled at each tick.
- R4: With mod_en_i = 0, the phase step equals the selected tuning word, whatever shift_i and pmod_i hold.
- R5: With mod_en_i = 1 and mod_src_i = 0, the step is the tuning word plus shift_i, modulo 2^28.
- R6: With mod_en_i = 1 and mod_src_i = 1, the step is the tuning word plus pmod_i sign-extended from bit 22 to 28 bits, modulo 2^28.
- R7: After reset the phase starts at 0. The sample presented after tick n is the sine of the phase accumulated over ticks 1 to n-1, and it is held between ticks.
- R8: A step of 2^25 gives an output period of exactly 8 samples.
- R9: A step in 0x8000000..0xFFFFFFF acts as a negative value, so the phase runs backwards and wraps modulo 2^28.
- R10: The sample equals 0x8000 + m when phase bit 27 is 0 and 0x8000 - m when it is 1. Here m is the table magnitude and the result is clamped to 0x0000..0xFFFF. Phases half a turn apart therefore give samples that sum to exactly 0x10000.
- R11: Phase bit 26 mirrors the table address. Top-eight-bit phase codes a and 127-a give identical samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, twice the sample rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| freq_a_i | input | 28 | Tuning word used when freq_sel_i = 0 |
| freq_b_i | input | 28 | Tuning word used when freq_sel_i = 1 |
| shift_i | input | 28 | Stored modulation offset |
| pmod_i | input | 23 | Parallel modulation offset, two's complement |
| freq_sel_i | input | 1 | Tuning word select |
| mod_src_i | input | 1 | Modulation source: 0 shift word, 1 parallel |
| mod_en_i | input | 1 | Modulation enable |
| sine_o | output | 16 | Offset-binary sine sample |
| valid_o | output | 1 | One-clock strobe per new sample |

## Verification
The bench goes after the sign extension of the parallel input. A zero-extending design would add roughly 2^23 too much per sample, and the phase would drift quickly away from the model. It also checks the quadrant handling with exact equalities: half-turn pairs must sum to 0x10000 and mirrored codes must match. Swapped mirroring or a dropped negation would break one of these exactly, with no tolerance involved. Negative steps, a 2^25 step with its strict 8-sample period, and the one-sample latency after reset are all compared against an independently computed sine. A skipped half-rate divider or an extra pipeline stage would shift every sample.

// File: rtl/dds_pkg.sv
package dds_pkg;
  typedef enum logic {
    MOD_FROM_SHIFT = 1'b0,
    MOD_FROM_PAR   = 1'b1
  } mod_src_e;

  // Quarter-wave magnitude at bin midpoint, rational sine approximation.
  function automatic longint unsigned quarter_mag(input int idx, input int addr_w,
                                                  input int out_w);
    longint n, u, p, amp, num, den;
    n   = longint'(1) << (addr_w + 2);
    u   = 2 * idx + 1;
    p   = u * (n - u);
    amp = (longint'(1) << (out_w - 1)) - 1;
    num = 4 * p * amp;
    den = (5 * n * n) / 4 - p;
    return longint'((num + den / 2) / den);
  endfunction
endpackage

// File: rtl/dds_tune_sum.sv
module dds_tune_sum
  import dds_pkg::*;
#(
  parameter int FW = 28,
  parameter int PW = 23
) (
  input  logic [FW-1:0] freq_a_i,
  input  logic [FW-1:0] freq_b_i,
  input  logic [FW-1:0] shift_i,
  input  logic [PW-1:0] pmod_i,
  input  logic          freq_sel_i,
  input  mod_src_e      mod_src_i,
  input  logic          mod_en_i,
  output logic [FW-1:0] step_o
);
  localparam int EXT_W = FW - PW;

  logic [FW-1:0] base;
  logic [FW-1:0] pmod_ext;
  logic [FW-1:0] mod_val;

  always_comb begin
    base     = freq_sel_i ? freq_b_i : freq_a_i;
    pmod_ext = {{EXT_W{pmod_i[PW-1]}}, pmod_i};
    mod_val  = (mod_src_i == MOD_FROM_PAR) ? pmod_ext : shift_i;
    step_o   = mod_en_i ? base + mod_val : base;
  end
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int FW   = 28,
  parameter int TOPW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [FW-1:0]   step_i,
  output logic            tick_o,
  output logic [TOPW-1:0] phase_top_o
);
  logic          div_q;
  logic [FW-1:0] phase_q;

  // Half-rate sample tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= 1'b0;
    else         div_q <= ~div_q;
  end

  assign tick_o = div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= '0;
    else if (tick_o) phase_q <= phase_q + step_i;
  end

  assign phase_top_o = phase_q[FW-1 -: TOPW];

  // R2
  tick_alt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  // R7
  phase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> $stable(phase_q));
endmodule

// File: rtl/dds_sine_map.sv
module dds_sine_map
  import dds_pkg::*;
#(
  parameter int AW    = 6,
  parameter int OUT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [AW+1:0]    phase_top_i,
  output logic [OUT_W-1:0] sine_o,
  output logic             valid_o
);
  localparam int LUT_N = 1 << AW;
  localparam int VW    = OUT_W + 2;
  localparam logic signed [VW-1:0] MID  = VW'(longint'(1) << (OUT_W - 1));
  localparam logic signed [VW-1:0] VMAX = VW'((longint'(1) << OUT_W) - 1);
  localparam logic [OUT_W-1:0]     MID_U = OUT_W'(longint'(1) << (OUT_W - 1));

  logic [OUT_W-1:0] lut [LUT_N];

  for (genvar g = 0; g < LUT_N; g++) begin : g_lut
    assign lut[g] = OUT_W'(quarter_mag(g, AW, OUT_W));
  end

  logic [1:0]             quad;
  logic [AW-1:0]          addr;
  logic [OUT_W-1:0]       mag;
  logic signed [VW-1:0]   val;
  logic [OUT_W-1:0]       sample;
  logic [OUT_W-1:0]       sine_q;
  logic                   valid_q;

  always_comb begin
    quad = phase_top_i[AW+1:AW];
    addr = quad[0] ? ~phase_top_i[AW-1:0] : phase_top_i[AW-1:0];
    mag  = lut[addr];
    val  = quad[1] ? MID - $signed({2'b00, mag}) : MID + $signed({2'b00, mag});
    if (val < 0)         sample = '0;
    else if (val > VMAX) sample = '1;
    else                 sample = val[OUT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sine_q  <= MID_U;
      valid_q <= 1'b0;
    end else begin
      valid_q <= tick_i;
      if (tick_i) sine_q <= sample;
    end
  end

  assign sine_o  = sine_q;
  assign valid_o = valid_q;

  // R2
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R7
  sine_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(sine_o));

  // R10
  pos_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !phase_top_i[AW+1]) |=> (sine_o >= MID_U));

  // R10
  neg_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && phase_top_i[AW+1]) |=> (sine_o < MID_U));
endmodule

// File: rtl/dds_sine_core.sv
module dds_sine_core
  import dds_pkg::*;
#(
  parameter int FW    = 28,
  parameter int PW    = 23,
  parameter int AW    = 6,
  parameter int OUT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [FW-1:0]    freq_a_i,
  input  logic [FW-1:0]    freq_b_i,
  input  logic [FW-1:0]    shift_i,
  input  logic [PW-1:0]    pmod_i,
  input  logic             freq_sel_i,
  input  logic             mod_src_i,
  input  logic             mod_en_i,
  output logic [OUT_W-1:0] sine_o,
  output logic             valid_o
);
  localparam int TOPW = AW + 2;

  logic [FW-1:0]   step;
  logic            tick;
  logic [TOPW-1:0] phase_top;

  dds_tune_sum #(.FW(FW), .PW(PW)) u_sum (
    .freq_a_i  (freq_a_i),
    .freq_b_i  (freq_b_i),
    .shift_i   (shift_i),
    .pmod_i    (pmod_i),
    .freq_sel_i(freq_sel_i),
    .mod_src_i (mod_src_e'(mod_src_i)),
    .mod_en_i  (mod_en_i),
    .step_o    (step)
  );

  dds_phase_acc #(.FW(FW), .TOPW(TOPW)) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step),
    .tick_o     (tick),
    .phase_top_o(phase_top)
  );

  dds_sine_map #(.AW(AW), .OUT_W(OUT_W)) u_map (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .phase_top_i(phase_top),
    .sine_o     (sine_o),
    .valid_o    (valid_o)
  );
endmodule

// File: tb/dds_sine_core_tb.sv
module dds_sine_core_tb_top;
  localparam int TOL = 80;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [27:0] freq_a = '0, freq_b = '0, shift_w = '0;
  logic [22:0] pmod = '0;
  logic        fsel = 1'b0, msrc = 1'b0, men = 1'b0;
  logic [15:0] sine;
  logic        valid;

  int checks = 0;
  int errors = 0;
  logic [27:0] mdl = '0;

  always #5 clk = ~clk;

  dds_sine_core dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .freq_a_i(freq_a), .freq_b_i(freq_b), .shift_i(shift_w), .pmod_i(pmod),
    .freq_sel_i(fsel), .mod_src_i(msrc), .mod_en_i(men),
    .sine_o(sine), .valid_o(valid)
  );

  function automatic int ideal(input logic [27:0] p);
    real ang;
    ang = 2.0 * 3.14159265358979 * (real'(p[27:20]) + 0.5) / 256.0;
    return 32768 + int'($rtoi($floor(32767.0 * $sin(ang) + 0.5)));
  endfunction

  function automatic logic [27:0] model_step();
    logic [27:0] b, m;
    b = fsel ? freq_b : freq_a;
    m = msrc ? {{5{pmod[22]}}, pmod} : shift_w;
    return men ? b + m : b;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(sine == 16'h8000, "R1 sine in reset", int'(sine), 32'h8000);
    chk(valid == 1'b0, "R1 valid in reset", int'(valid), 0);
    mdl = '0;
    rst_n = 1'b1;
  endtask

  task automatic next_sample(output logic [15:0] s);
    do @(negedge clk); while (!valid);
    s = sine;
  endtask

  // Compare one sample against the model, then advance the model.
  task automatic step_chk(input string req);
    logic [15:0] s;
    int e, d;
    next_sample(s);
    e = ideal(mdl);
    d = int'(s) - e;
    if (d < 0) d = -d;
    chk(d <= TOL, req, int'(s), e);
    mdl = mdl + model_step();
  endtask

  task automatic t_reset_timing();
    freq_a = 28'h0A3D70A; fsel = 0; men = 0;
    do_reset();
    step_chk("R7 first sample from zero phase");
    @(negedge clk);
    chk(valid == 1'b0, "R2 valid low between ticks", int'(valid), 0);
    @(negedge clk);
    chk(valid == 1'b1, "R2 valid two clocks apart", int'(valid), 1);
    mdl = mdl + model_step();
    for (int i = 0; i < 4; i++) step_chk("R7 accumulate");
  endtask

  task automatic t_select();
    freq_a = 28'h0A3D70A; freq_b = 28'h3333333; men = 0; fsel = 0;
    do_reset();
    for (int i = 0; i < 5; i++) step_chk("R3 word A");
    fsel = 1;
    for (int i = 0; i < 6; i++) step_chk("R3 word B");
    fsel = 0;
    for (int i = 0; i < 4; i++) step_chk("R3 back to A");
  endtask

  task automatic t_mod_shift();
    freq_a = 28'h0800000; fsel = 0; shift_w = 28'h1800000; pmod = 23'h1FFFFF;
    men = 1; msrc = 0;
    do_reset();
    for (int i = 0; i < 8; i++) step_chk("R5 shift modulation");
    men = 0;
    for (int i = 0; i < 6; i++) step_chk("R4 modulation off");
  endtask

  task automatic t_mod_par();
    freq_a = 28'h2000000; fsel = 0; shift_w = 28'h0400000; pmod = 23'h600000;
    men = 1; msrc = 1;
    do_reset();
    for (int i = 0; i < 10; i++) step_chk("R6 negative parallel offset");
    pmod = 23'h0C0000;
    for (int i = 0; i < 6; i++) step_chk("R6 positive parallel offset");
  endtask

  task automatic t_eighth();
    logic [15:0] buf_s [16];
    freq_a = 28'h2000000; fsel = 0; men = 0;
    do_reset();
    for (int i = 0; i < 16; i++) begin
      step_chk("R8 eighth-rate tone");
      buf_s[i] = sine;
    end
    for (int i = 0; i < 8; i++)
      chk(buf_s[i] == buf_s[i+8], "R8 period of 8", int'(buf_s[i+8]), int'(buf_s[i]));
  endtask

  task automatic t_reverse();
    freq_a = 28'hE000000; fsel = 0; men = 0;
    do_reset();
    for (int i = 0; i < 10; i++) step_chk("R9 negative step");
    freq_a = 28'hFF5C290;
    for (int i = 0; i < 6; i++) step_chk("R9 small negative step");
  endtask

  task automatic t_half();
    logic [15:0] s0, s1;
    freq_a = 28'h8000000; fsel = 0; men = 0;
    do_reset();
    next_sample(s0);
    next_sample(s1);
    chk(32'(s0) + 32'(s1) == 32'h10000, "R10 half-turn complement", int'(s0) + int'(s1), 32'h10000);
    chk(s1 < 16'h8000, "R10 negative half below mid", int'(s1), 32'h7FFF);
  endtask

  task automatic t_mirror();
    logic [15:0] s0, s1;
    freq_a = 28'h7F00000; fsel = 0; men = 0;
    do_reset();
    next_sample(s0);
    next_sample(s1);
    chk(s0 == s1, "R11 mirrored address", int'(s1), int'(s0));
  endtask

  initial begin
    #(1_500_000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset_timing();
    t_select();
    t_mod_shift();
    t_mod_par();
    t_eighth();
    t_reverse();
    t_half();
    t_mirror();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule